// File: doc/BRIEF.md
# Retriggerable Power-Management Countdown Timer

This block is a down-counter used by power-management logic to detect a period with no activity. Software stores an 8-bit reload byte. When the timer is switched on, that byte is copied into the counter. In wide mode the byte is first moved into the upper half of a 16-bit count, so the timer can run for much longer. The counter steps down once on each pulse of the selected time base, which is either a millisecond tick or a second tick, both supplied from outside. When the count runs out, the block raises a one-cycle interrupt request and sets a status flag. The flag stays set until software writes a clear.

Activity can hold off expiry. A rising edge on an external pin, when allowed, puts the reload value back into the counter. Once the timer has expired it stays idle. It starts again only when it is switched off and on, or when a new reload byte is written while it is on.

Top module: `retrig_countdown_timer`

## Requirements
- R1: After reset, the interrupt request and the status flag are 0 and the reload byte is 00h. Turning the timer on without a prior write therefore loads a count of 0.
- R2: With `wide_mode` = 0, a 0-to-1 change of `arm_en` loads the reload byte N as the count. On the N-th selected tick after that load, the timer expires. A count of 0 or 1 expires on the first tick.
- R3: With `wide_mode` = 1, the loaded count is N shifted left by 8, with the low byte equal to zero. N = 1 therefore expires on the 256th tick.
- R4: With `base_fast` = 1, only `tick_ms` steps the counter. With `base_fast` = 0, only `tick_s` steps it.
- R5: At expiry, `irq_pulse` is high for exactly one cycle, and `expired_stat` goes to 1 on that same cycle. `expired_stat` stays 1 until a cycle with `stat_clr` = 1. When expiry and `stat_clr` fall on the same cycle, the flag is set.
- R6: After expiry, the timer does not reload on its own, and pin edges do not wake it. It restarts on a fresh 0-to-1 change of `arm_en`, or on a `wr_load` pulse while `arm_en` = 1. A `wr_load` pulse reloads from the byte written in that same cycle.
- R7: While the timer is running, with `retrig_en` = 1 and `pin_is_input` = 1, a rising edge on `retrig_pin` reloads the count. The pin goes through a two-flop synchronizer, so the reload lands on the third clock edge after the pin rises.
- R8: Pin edges have no effect when `retrig_en` = 0 or `pin_is_input` = 0.
- R9: When a reload and a selected tick occur in the same cycle, the count takes the reload value and that tick is not counted.
- R10: While `arm_en` = 0, the timer neither counts nor expires.
- R11: A `wr_load` pulse while `arm_en` = 0 only stores the byte. The stored byte is loaded at the next 0-to-1 change of `arm_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_load | input | 1 | Write strobe for the reload byte |
| wr_data | input | 8 | Reload byte written on a `wr_load` pulse |
| arm_en | input | 1 | Timer on (1) or off (0) |
| wide_mode | input | 1 | 1 moves the reload byte into the upper half of a 16-bit count |
| base_fast | input | 1 | Time base select: 1 uses `tick_ms`, 0 uses `tick_s` |
| retrig_en | input | 1 | Allows pin edges to reload the count |
| pin_is_input | input | 1 | The pin is configured as an input; gates the retrigger |
| retrig_pin | input | 1 | External activity pin, asynchronous |
| tick_ms | input | 1 | Millisecond tick, one-cycle pulse |
| tick_s | input | 1 | Second tick, one-cycle pulse |
| stat_clr | input | 1 | Clears the status flag |
| expired_stat | output | 1 | Sticky expiry flag |
| irq_pulse | output | 1 | One-cycle management-interrupt request |

## Verification
The assertions assume the following about the inputs:
- All inputs other than `retrig_pin` are synchronous to `clk`.
- `retrig_pin` may change at any time, because only its synchronized copy is used.

The bench changes every input at the falling clock edge. It holds each pin level for at least two cycles, so every edge passes through the synchronizer. It makes reloads coincide with ticks so that the reload-over-tick rule is exercised. It compares outputs on every cycle against a behavioural model.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_ARM    = 2'd1,
      SRC_WRITE  = 2'd2,
      SRC_RETRIG = 2'd3
   } reload_src_e;
endpackage

// File: rtl/pmt_edge_sync.sv
module pmt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic pin_rise
);
   initial begin : p_param_chk
      assert (STAGES >= 2) else $error("pmt_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain[0] <= 1'b0;
      end else begin
         chain[0] <= pin_async;
      end
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[g] <= 1'b0;
         end else begin
            chain[g] <= chain[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_seen <= 1'b0;
      end else begin
         last_seen <= chain[STAGES-1];
      end
   end

   assign pin_rise = chain[STAGES-1] & ~last_seen;

   a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      pin_rise |=> !pin_rise);
endmodule

// File: rtl/pmt_load_reg.sv
module pmt_load_reg #(
   parameter int LOAD_W   = 8,
   parameter int CNT_W    = 16,
   parameter bit HAS_WIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_load,
   input  logic [LOAD_W-1:0] wr_data,
   input  logic              wide_mode,
   output logic [CNT_W-1:0]  load_val
);
   localparam int SHIFT = CNT_W - LOAD_W;

   initial begin : p_param_chk
      assert (LOAD_W > 0) else $error("pmt_load_reg: LOAD_W must be positive");
      assert (CNT_W >= LOAD_W) else $error("pmt_load_reg: CNT_W below LOAD_W");
   end

   logic [LOAD_W-1:0] held;
   logic [LOAD_W-1:0] byte_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= '0;
      end else if (wr_load) begin
         held <= wr_data;
      end
   end

   assign byte_now = wr_load ? wr_data : held;

   if (HAS_WIDE && SHIFT > 0) begin : g_wide
      always_comb begin
         if (wide_mode) begin
            load_val = {byte_now, {SHIFT{1'b0}}};
         end else begin
            load_val = CNT_W'(byte_now);
         end
      end
   end else begin : g_narrow
      logic unused_mode;
      assign unused_mode = wide_mode;
      assign load_val    = CNT_W'(byte_now);
   end
endmodule

// File: rtl/pmt_down_core.sv
module pmt_down_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             reload,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             stat_clr,
   output logic             running,
   output logic             irq,
   output logic             stat
);
   logic [CNT_W-1:0] cnt;
   logic             expire_now;

   assign expire_now = arm & ~reload & running & tick & (cnt <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
         irq     <= 1'b0;
      end else begin
         irq <= expire_now;
         if (!arm) begin
            running <= 1'b0;
         end else if (reload) begin
            cnt     <= load_val;
            running <= 1'b1;
         end else if (running && tick) begin
            if (expire_now) begin
               cnt     <= '0;
               running <= 1'b0;
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= 1'b0;
      end else if (expire_now) begin
         stat <= 1'b1;
      end else if (stat_clr) begin
         stat <= 1'b0;
      end
   end

   a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   a_r5_irq_flags: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> stat);
   a_r5_stat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat && !stat_clr) |=> stat);
   a_r9_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && reload) |=> (cnt == $past(load_val)) && running && !irq);
   a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> !irq && !running);
   a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !reload) |=> $stable(cnt) && !irq);
endmodule

// File: rtl/retrig_countdown_timer.sv
module retrig_countdown_timer
   import pmt_pkg::*;
#(
   parameter int LOAD_W      = 8,
   parameter int CNT_W       = 16,
   parameter bit HAS_WIDE    = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_load,
   input  logic [LOAD_W-1:0] wr_data,
   input  logic              arm_en,
   input  logic              wide_mode,
   input  logic              base_fast,
   input  logic              retrig_en,
   input  logic              pin_is_input,
   input  logic              retrig_pin,
   input  logic              tick_ms,
   input  logic              tick_s,
   input  logic              stat_clr,
   output logic              expired_stat,
   output logic              irq_pulse
);
   logic             arm_q;
   logic             pin_rise;
   logic [CNT_W-1:0] load_val;
   logic             running;
   logic             tick_sel;
   reload_src_e      src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
      end else begin
         arm_q <= arm_en;
      end
   end

   pmt_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (retrig_pin),
      .pin_rise  (pin_rise)
   );

   pmt_load_reg #(.LOAD_W(LOAD_W), .CNT_W(CNT_W), .HAS_WIDE(HAS_WIDE)) i_load (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_load   (wr_load),
      .wr_data   (wr_data),
      .wide_mode (wide_mode),
      .load_val  (load_val)
   );

   always_comb begin
      src = SRC_NONE;
      if (arm_en && !arm_q) begin
         src = SRC_ARM;
      end else if (wr_load) begin
         src = SRC_WRITE;
      end else if (running && retrig_en && pin_is_input && pin_rise) begin
         src = SRC_RETRIG;
      end
   end

   assign tick_sel = base_fast ? tick_ms : tick_s;

   pmt_down_core #(.CNT_W(CNT_W)) i_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm_en),
      .reload   (src != SRC_NONE),
      .load_val (load_val),
      .tick     (tick_sel),
      .stat_clr (stat_clr),
      .running  (running),
      .irq      (irq_pulse),
      .stat     (expired_stat)
   );

   a_r8_gate_blocks_retrig: assert property (@(posedge clk) disable iff (!rst_n)
      (!retrig_en || !pin_is_input) |-> (src != SRC_RETRIG));
   a_r2_arm_rise_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_en && !arm_q) |=> running);
endmodule

// File: tb/test_retrig_countdown_timer.sv
module test_retrig_countdown_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_load = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       arm_en = 1'b0;
   logic       wide_mode = 1'b0;
   logic       base_fast = 1'b1;
   logic       retrig_en = 1'b0;
   logic       pin_is_input = 1'b0;
   logic       retrig_pin = 1'b0;
   logic       tick_ms = 1'b0;
   logic       tick_s = 1'b0;
   logic       stat_clr = 1'b0;
   logic       expired_stat;
   logic       irq_pulse;

   int    total = 0;
   int    bad = 0;
   int    irq_seen = 0;
   int    cycles = 0;
   int    ms_per = 1;
   int    s_per = 3;
   int    ms_div = 0;
   int    s_div = 0;
   string cur_req = "R1";

   int m_cnt = 0;
   bit m_run = 0, m_irq = 0, m_stat = 0, m_arm_q = 0;
   bit m_s1 = 0, m_s2 = 0, m_prev = 0;
   int m_load = 0;

   always #10 clk = ~clk;

   retrig_countdown_timer i_retrig_countdown_timer (
      .clk(clk), .rst_n(rst_n), .wr_load(wr_load), .wr_data(wr_data),
      .arm_en(arm_en), .wide_mode(wide_mode), .base_fast(base_fast),
      .retrig_en(retrig_en), .pin_is_input(pin_is_input), .retrig_pin(retrig_pin),
      .tick_ms(tick_ms), .tick_s(tick_s), .stat_clr(stat_clr),
      .expired_stat(expired_stat), .irq_pulse(irq_pulse)
   );

   always @(negedge clk) begin
      ms_div  = (ms_div + 1) % ms_per;
      s_div   = (s_div + 1) % s_per;
      tick_ms <= (ms_div == 0);
      tick_s  <= (s_div == 0);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_run = 0; m_irq = 0; m_stat = 0; m_arm_q = 0;
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_load = 0;
      end else begin
         bit edge_m, rise, reload, tk, fire;
         int nl;
         edge_m = m_s2 && !m_prev;
         nl     = wr_load ? int'(wr_data) : m_load;
         rise   = arm_en && !m_arm_q;
         reload = arm_en && (rise || wr_load ||
                  (m_run && retrig_en && pin_is_input && edge_m));
         tk     = base_fast ? tick_ms : tick_s;
         fire   = 0;
         if (!arm_en) m_run = 0;
         else if (reload) begin
            m_cnt = wide_mode ? nl * 256 : nl;
            m_run = 1;
         end else if (m_run && tk) begin
            if (m_cnt <= 1) begin m_cnt = 0; m_run = 0; fire = 1; end
            else m_cnt = m_cnt - 1;
         end
         if (fire) m_stat = 1; else if (stat_clr) m_stat = 0;
         m_irq   = fire;
         m_load  = nl;
         m_arm_q = arm_en;
         m_prev  = m_s2; m_s2 = m_s1; m_s1 = retrig_pin;
      end
   end

   task automatic check(string req, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check(cur_req, "irq_pulse", int'(irq_pulse), int'(m_irq));
         check(cur_req, "expired_stat", int'(expired_stat), int'(m_stat));
         if (irq_pulse) irq_seen++;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_byte(int v);
      wr_data = 8'(v);
      wr_load = 1'b1;
      @(negedge clk);
      wr_load = 1'b0;
   endtask

   task automatic expect_irqs(string req, int start, int n);
      check(req, "irq count", irq_seen - start, n);
   endtask

   task automatic pin_pulses(int n);
      for (int i = 0; i < n; i++) begin
         retrig_pin = 1'b1; wait_cyc(3);
         retrig_pin = 1'b0; wait_cyc(3);
      end
   endtask

   initial begin
      int mark;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      check("R1", "irq after reset", int'(irq_pulse), 0);
      check("R1", "stat after reset", int'(expired_stat), 0);

      cur_req = "R1"; mark = irq_seen;
      arm_en = 1'b1; wait_cyc(5);
      expect_irqs("R1", mark, 1);
      check("R5", "stat after expiry", int'(expired_stat), 1);

      cur_req = "R5"; stat_clr = 1'b1; wait_cyc(1); stat_clr = 1'b0; wait_cyc(1);
      check("R5", "stat after clear", int'(expired_stat), 0);

      cur_req = "R10"; arm_en = 1'b0; mark = irq_seen;
      write_byte(6); wait_cyc(20);
      expect_irqs("R10", mark, 0);
      cur_req = "R11"; mark = irq_seen; arm_en = 1'b1; wait_cyc(10);
      expect_irqs("R11", mark, 1);
      cur_req = "R6"; mark = irq_seen; wait_cyc(10);
      expect_irqs("R6", mark, 0);

      mark = irq_seen; write_byte(3); wait_cyc(8);
      expect_irqs("R6", mark, 1);

      cur_req = "R5"; mark = irq_seen; stat_clr = 1'b1;
      write_byte(2); wait_cyc(6); stat_clr = 1'b0; wait_cyc(1);
      expect_irqs("R5", mark, 1);
      check("R5", "stat held clear", int'(expired_stat), 0);

      cur_req = "R3"; arm_en = 1'b0; wide_mode = 1'b1; write_byte(1);
      mark = irq_seen; arm_en = 1'b1; wait_cyc(250);
      expect_irqs("R3", mark, 0);
      wait_cyc(20);
      expect_irqs("R3", mark, 1);
      wide_mode = 1'b0;

      cur_req = "R4"; arm_en = 1'b0; write_byte(4); base_fast = 1'b0;
      mark = irq_seen; arm_en = 1'b1; wait_cyc(9);
      expect_irqs("R4", mark, 0);
      wait_cyc(20);
      expect_irqs("R4", mark, 1);
      base_fast = 1'b1;

      cur_req = "R7"; arm_en = 1'b0; ms_per = 2; retrig_en = 1'b1; pin_is_input = 1'b1;
      write_byte(8); mark = irq_seen; arm_en = 1'b1; wait_cyc(1);
      pin_pulses(10);
      expect_irqs("R7", mark, 0);
      wait_cyc(30);
      expect_irqs("R7", mark, 1);

      cur_req = "R8"; retrig_en = 1'b0; mark = irq_seen; write_byte(8);
      pin_pulses(10);
      expect_irqs("R8", mark, 1);
      retrig_en = 1'b1; pin_is_input = 1'b0; mark = irq_seen; write_byte(8);
      pin_pulses(10);
      expect_irqs("R8", mark, 1);
      retrig_en = 1'b0;

      cur_req = "R9"; ms_per = 1; wait_cyc(2);
      write_byte(5); wait_cyc(2); mark = irq_seen; write_byte(5); wait_cyc(4);
      expect_irqs("R9", mark, 0);
      wait_cyc(3);
      expect_irqs("R9", mark, 1);

      cur_req = "R10"; write_byte(5); wait_cyc(2); arm_en = 1'b0; mark = irq_seen;
      wait_cyc(20);
      expect_irqs("R10", mark, 0);
      cur_req = "R2"; arm_en = 1'b1; wait_cyc(8);
      expect_irqs("R2", mark, 1);

      wait_cyc(4);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule